// File: doc/BRIEF.md
# SCSI Bus Event Interrupt Status

This block gathers eight SCSI bus events into a single sticky status byte and raises an interrupt line toward the host processor while any of them is pending. The protocol engine feeds it one-cycle event pulses. The block also receives the data-bus ID byte sampled during (re)selection, the current bus role and a flag that marks an ATN assertion the protocol expects. From these inputs it decides which events deserve a flag.

Three events are qualified before they are recorded. An ID-population error is derived from the sampled ID byte on a sampling strobe. An ATN assertion is suppressed while the engine reports an expected ATN sequence. A phase-change error counts only when the controller acts as initiator. Recording the select-without-ATN event has no side effect on the rest of the controller.

The host reads the status byte and clears flags by writing the same value back. Each 1 written clears the matching flag and each 0 written leaves it alone. A flag that is set again in the cycle it is cleared stays set.

Top module: `scsi_evt_irq_status`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the status byte reads 0x00 and the interrupt output is low.
- R2: Each accepted event sets its flag, readable on the clock after the pulse is sampled. Flag positions: bit7 parity error, bit6 ID error, bit5 selection timeout, bit4 unexpected ATN, bit3 bus free, bit2 illegal phase change, bit1 SCAM selection, bit0 selected without ATN.
- R3: A set flag stays set on every following cycle until the host clears it.
- R4: A host write clears exactly the flags whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: When an event for a flag and a host clear of that flag occur in the same cycle, the flag ends up set.
- R6: With the ID strobe high, the ID error flag (bit6) sets when exactly one bit, or three or more bits, of the 8-bit ID byte are 1. Zero or exactly two set bits do not set it.
- R7: With the ID strobe low, the ID byte has no effect on bit6.
- R8: An ATN pulse while the expected-ATN flag is high leaves bit4 unchanged.
- R9: A phase-change pulse sets bit2 only when the role input is 1 (initiator). With role 0 (target) the pulse leaves bit2 unchanged.
- R10: The interrupt output is high exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_parity | input | 1 | Data parity error pulse |
| ev_sel_timeout | input | 1 | Selection/reselection timeout pulse |
| ev_atn | input | 1 | ATN assertion pulse |
| ev_bus_free | input | 1 | Bus free seen during a command |
| ev_phase_chg | input | 1 | Unexpected phase transition pulse |
| ev_scam_sel | input | 1 | SCAM selection answered |
| ev_sel_no_atn | input | 1 | Selection without ATN answered |
| id_bus | input | 8 | Data-bus ID byte sampled in (re)selection |
| id_strobe | input | 1 | Marks the cycle at which id_bus is evaluated |
| role_initiator | input | 1 | 1 = initiator role, 0 = target role |
| atn_expected | input | 1 | ATN assertion is part of the expected sequence |
| cpu_wr | input | 1 | Host write strobe (write-back clear) |
| cpu_wdata | input | 8 | Host write data, 1 bits clear flags |
| cpu_rdata | output | 8 | Current status byte |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
Each event pulse, ID strobe and host write is sampled at one rising edge, and its effect is due on the status byte right after that same edge. There is one register stage. The interrupt follows the status byte in the same cycle because it is combinational from the flags. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and outputs are compared on the next falling edge, which is exactly one register stage after the stimulus. Set-versus-clear collisions and the qualified events are checked in that same window.

// File: rtl/scsi_evt_pkg.sv
package scsi_evt_pkg;

    localparam int STS_W     = 8;
    localparam int BIT_PAR   = 7;
    localparam int BIT_IDERR = 6;
    localparam int BIT_SELTO = 5;
    localparam int BIT_ATN   = 4;
    localparam int BIT_BFREE = 3;
    localparam int BIT_PHASE = 2;
    localparam int BIT_SCAM  = 1;
    localparam int BIT_NOATN = 0;

    // Packed MSB-first so the struct maps straight onto the status byte.
    typedef struct packed {
        logic parity;
        logic id_err;
        logic sel_to;
        logic atn;
        logic bus_free;
        logic phase;
        logic scam;
        logic no_atn;
    } evt_vec_t;

    typedef enum logic {
        ROLE_TARGET    = 1'b0,
        ROLE_INITIATOR = 1'b1
    } bus_role_t;

    function automatic logic role_is_initiator(input bus_role_t r);
        return r == ROLE_INITIATOR;
    endfunction

endpackage

// File: rtl/scsi_evt_idchk.sv
module scsi_evt_idchk #(
    parameter int ID_W      = 8,
    parameter int LEGAL_CNT = 2
) (
    input  logic [ID_W-1:0] id_bus,
    input  logic            id_strobe,
    output logic            id_err
);
    localparam int CNT_W = $clog2(ID_W + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < ID_W; i++) begin
            ones = ones + CNT_W'(id_bus[i]);
        end
    end

    // An empty bus is not a selection; only the legal count passes.
    always_comb begin
        id_err = id_strobe && (ones != '0) && (ones != CNT_W'(LEGAL_CNT));
    end

endmodule

// File: rtl/scsi_evt_qual.sv
module scsi_evt_qual
    import scsi_evt_pkg::*;
(
    input  logic      ev_parity,
    input  logic      ev_sel_timeout,
    input  logic      ev_atn,
    input  logic      ev_bus_free,
    input  logic      ev_phase_chg,
    input  logic      ev_scam_sel,
    input  logic      ev_sel_no_atn,
    input  logic      id_err,
    input  bus_role_t role,
    input  logic      atn_expected,
    output evt_vec_t  set_vec
);
    always_comb begin
        set_vec          = '0;
        set_vec.parity   = ev_parity;
        set_vec.id_err   = id_err;
        set_vec.sel_to   = ev_sel_timeout;
        set_vec.atn      = ev_atn && !atn_expected;
        set_vec.bus_free = ev_bus_free;
        set_vec.phase    = ev_phase_chg && role_is_initiator(role);
        set_vec.scam     = ev_scam_sel;
        set_vec.no_atn   = ev_sel_no_atn;
    end

endmodule

// File: rtl/scsi_evt_stsreg.sv
module scsi_evt_stsreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[g] <= 1'b0;
                end else if (set_bits[g]) begin
                    q[g] <= 1'b1;
                end else if (clr_en && clr_mask[g]) begin
                    q[g] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/scsi_evt_irq_status.sv
module scsi_evt_irq_status
    import scsi_evt_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int LEGAL_CNT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ev_parity,
    input  logic            ev_sel_timeout,
    input  logic            ev_atn,
    input  logic            ev_bus_free,
    input  logic            ev_phase_chg,
    input  logic            ev_scam_sel,
    input  logic            ev_sel_no_atn,
    input  logic [ID_W-1:0] id_bus,
    input  logic            id_strobe,
    input  logic            role_initiator,
    input  logic            atn_expected,
    input  logic            cpu_wr,
    input  logic [STS_W-1:0] cpu_wdata,
    output logic [STS_W-1:0] cpu_rdata,
    output logic            irq
);
    logic       id_err;
    evt_vec_t   set_vec;
    bus_role_t  role;
    logic [STS_W-1:0] sts_q;

    assign role = bus_role_t'(role_initiator);

    scsi_evt_idchk #(
        .ID_W      (ID_W),
        .LEGAL_CNT (LEGAL_CNT)
    ) u_idchk (
        .id_bus    (id_bus),
        .id_strobe (id_strobe),
        .id_err    (id_err)
    );

    scsi_evt_qual u_qual (
        .ev_parity      (ev_parity),
        .ev_sel_timeout (ev_sel_timeout),
        .ev_atn         (ev_atn),
        .ev_bus_free    (ev_bus_free),
        .ev_phase_chg   (ev_phase_chg),
        .ev_scam_sel    (ev_scam_sel),
        .ev_sel_no_atn  (ev_sel_no_atn),
        .id_err         (id_err),
        .role           (role),
        .atn_expected   (atn_expected),
        .set_vec        (set_vec)
    );

    scsi_evt_stsreg #(
        .W (STS_W)
    ) u_sts (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_vec),
        .clr_en   (cpu_wr),
        .clr_mask (cpu_wdata),
        .q        (sts_q)
    );

    assign cpu_rdata = sts_q;
    assign irq       = |sts_q;

endmodule

// File: rtl/scsi_evt_irq_status_chk.sv
module scsi_evt_irq_status_chk
    import scsi_evt_pkg::*;
#(
    parameter int ID_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_parity,
    input logic             ev_atn,
    input logic             ev_phase_chg,
    input logic [ID_W-1:0]  id_bus,
    input logic             id_strobe,
    input logic             role_initiator,
    input logic             atn_expected,
    input logic             cpu_wr,
    input logic [STS_W-1:0] cpu_wdata,
    input logic [STS_W-1:0] cpu_rdata,
    input logic             irq
);
    logic             rst_q;
    logic [STS_W-1:0] clr_now;

    assign clr_now = cpu_wr ? cpu_wdata : '0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_clear_R1: assert (cpu_rdata == '0 && !irq)
                else $error("status not cleared by reset");
        end
    end

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(cpu_rdata) & ~$past(clr_now) & ~cpu_rdata) == '0));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_parity && cpu_wr && cpu_wdata[BIT_PAR]) |=> cpu_rdata[BIT_PAR]);

    assert_single_id_R6: assert property (@(posedge clk) disable iff (rst)
        (id_strobe && $countones(id_bus) == 1) |=> cpu_rdata[BIT_IDERR]);

    assert_atn_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (atn_expected && !cpu_rdata[BIT_ATN]) |=> !cpu_rdata[BIT_ATN]);

    assert_target_phase_R9: assert property (@(posedge clk) disable iff (rst)
        (!role_initiator && !cpu_rdata[BIT_PHASE]) |=> !cpu_rdata[BIT_PHASE]);

    assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
        irq == (cpu_rdata != '0));

    assert_phase_init_R9: assert property (@(posedge clk) disable iff (rst)
        (role_initiator && ev_phase_chg) |=> cpu_rdata[BIT_PHASE]);

    assert_atn_open_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_atn && !atn_expected) |=> cpu_rdata[BIT_ATN]);

endmodule

bind scsi_evt_irq_status scsi_evt_irq_status_chk #(.ID_W(ID_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_parity      (ev_parity),
    .ev_atn         (ev_atn),
    .ev_phase_chg   (ev_phase_chg),
    .id_bus         (id_bus),
    .id_strobe      (id_strobe),
    .role_initiator (role_initiator),
    .atn_expected   (atn_expected),
    .cpu_wr         (cpu_wr),
    .cpu_wdata      (cpu_wdata),
    .cpu_rdata      (cpu_rdata),
    .irq            (irq)
);

// File: tb/scsi_evt_irq_status_bench.sv
module scsi_evt_irq_status_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_parity = 0, ev_sel_timeout = 0, ev_atn = 0, ev_bus_free = 0;
    logic       ev_phase_chg = 0, ev_scam_sel = 0, ev_sel_no_atn = 0;
    logic [7:0] id_bus = 8'h00;
    logic       id_strobe = 0;
    logic       role_initiator = 1;
    logic       atn_expected = 0;
    logic       cpu_wr = 0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    armed = 0;
    string cur_req = "R1";
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    scsi_evt_irq_status u_scsi_evt_irq_status (
        .clk            (clk),
        .rst            (rst),
        .ev_parity      (ev_parity),
        .ev_sel_timeout (ev_sel_timeout),
        .ev_atn         (ev_atn),
        .ev_bus_free    (ev_bus_free),
        .ev_phase_chg   (ev_phase_chg),
        .ev_scam_sel    (ev_scam_sel),
        .ev_sel_no_atn  (ev_sel_no_atn),
        .id_bus         (id_bus),
        .id_strobe      (id_strobe),
        .role_initiator (role_initiator),
        .atn_expected   (atn_expected),
        .cpu_wr         (cpu_wr),
        .cpu_wdata      (cpu_wdata),
        .cpu_rdata      (cpu_rdata),
        .irq            (irq)
    );

    // Behavioural reference: what the requirements say happens at an edge.
    always @(posedge clk) begin
        logic [7:0] nxt;
        int ones;
        if (rst) begin
            model <= 8'h00;
        end else begin
            nxt = model;
            if (cpu_wr) nxt = nxt & ~cpu_wdata;
            ones = 0;
            for (int i = 0; i < 8; i++) ones += int'(id_bus[i]);
            if (ev_parity)                           nxt[7] = 1'b1;
            if (id_strobe && (ones == 1 || ones >= 3)) nxt[6] = 1'b1;
            if (ev_sel_timeout)                      nxt[5] = 1'b1;
            if (ev_atn && !atn_expected)             nxt[4] = 1'b1;
            if (ev_bus_free)                         nxt[3] = 1'b1;
            if (ev_phase_chg && role_initiator)      nxt[2] = 1'b1;
            if (ev_scam_sel)                         nxt[1] = 1'b1;
            if (ev_sel_no_atn)                       nxt[0] = 1'b1;
            model <= nxt;
        end
        cycles++;
        armed = 1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (cpu_rdata !== model) begin
                failures++;
                $display("FAIL %s status actual=%02h expected=%02h", cur_req, cpu_rdata, model);
            end
            checks++;
            if (irq !== (model != 8'h00)) begin
                failures++;
                $display("FAIL R10 irq actual=%0b expected=%0b", irq, model != 8'h00);
            end
        end
    end

    task automatic quiet();
        ev_parity = 0; ev_sel_timeout = 0; ev_atn = 0; ev_bus_free = 0;
        ev_phase_chg = 0; ev_scam_sel = 0; ev_sel_no_atn = 0;
        id_strobe = 0; cpu_wr = 0; cpu_wdata = 8'h00;
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic next_cycle();
        tick();
        quiet();
    endtask

    task automatic host_clear(input logic [7:0] v);
        cpu_wr = 1; cpu_wdata = v;
        next_cycle();
    endtask

    task automatic id_probe(input logic [7:0] v, input logic stb);
        id_bus = v; id_strobe = stb;
        next_cycle();
        host_clear(8'hFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        quiet();
        cur_req = "R1";
        tick(3);
        rst = 0;
        tick(2);

        cur_req = "R2";
        ev_parity = 1;      next_cycle();
        ev_sel_timeout = 1; next_cycle();
        ev_atn = 1;         next_cycle();
        ev_bus_free = 1;    next_cycle();
        ev_phase_chg = 1;   next_cycle();
        ev_scam_sel = 1;    next_cycle();
        ev_sel_no_atn = 1;  next_cycle();
        id_bus = 8'h04; id_strobe = 1; next_cycle();

        cur_req = "R3";
        tick(4);

        cur_req = "R4";
        host_clear(8'h0F);
        tick(1);
        host_clear(8'h00);
        host_clear(8'hA0);
        host_clear(8'hFF);

        cur_req = "R5";
        ev_parity = 1; ev_bus_free = 1; cpu_wr = 1; cpu_wdata = 8'h88;
        next_cycle();
        tick(1);
        host_clear(8'hFF);

        cur_req = "R6";
        id_probe(8'h00, 1);
        id_probe(8'h80, 1);
        id_probe(8'h11, 1);
        id_probe(8'h07, 1);
        id_probe(8'hFF, 1);
        id_probe(8'h81, 1);

        cur_req = "R7";
        id_probe(8'h01, 0);
        id_probe(8'hEF, 0);

        cur_req = "R8";
        atn_expected = 1; ev_atn = 1; next_cycle();
        tick(1);
        atn_expected = 0; ev_atn = 1; next_cycle();
        host_clear(8'hFF);

        cur_req = "R9";
        role_initiator = 0; ev_phase_chg = 1; next_cycle();
        tick(1);
        role_initiator = 1; ev_phase_chg = 1; next_cycle();
        host_clear(8'hFF);

        cur_req = "R10";
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ev_parity      = lfsr[0] & lfsr[5] & lfsr[9];
            ev_sel_timeout = lfsr[1] & lfsr[6] & lfsr[10];
            ev_atn         = lfsr[2] & lfsr[7];
            ev_bus_free    = lfsr[3] & lfsr[8] & lfsr[11];
            ev_phase_chg   = lfsr[4] & lfsr[12];
            ev_scam_sel    = lfsr[5] & lfsr[13] & lfsr[1];
            ev_sel_no_atn  = lfsr[6] & lfsr[14] & lfsr[2];
            id_bus         = lfsr[15:8];
            id_strobe      = lfsr[3] & lfsr[14];
            role_initiator = lfsr[9];
            atn_expected   = lfsr[11];
            cpu_wr         = lfsr[7] & lfsr[0];
            cpu_wdata      = lfsr[12:5];
            tick(1);
        end
        quiet();
        tick(2);

        cur_req = "R1";
        rst = 1;
        tick(2);
        rst = 0;
        tick(2);
        finish_run();
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired after %0d cycles expected finish", cycles);
        finish_run();
    end

endmodule